// File: doc/BRIEF.md
# Hard Reset Suspend Pulse Sequencer

This block carries out a software-commanded hard reset inside a power management controller. A bus write to the reset control port, with both the go bit and the arm bit set, starts a sequence. On the next clock edge two active-low suspend-plane outputs go low. They stay low for a fixed number of slow real-time-clock ticks. The RTC clock reaches the block as a single-cycle enable in the main clock domain. While the sequence runs, the system reset output is held asserted.

The supply may react to the suspend pulse by dropping power-good, or it may not. If power-good stays high for the whole pulse, the block finishes a warm hard reset and releases system reset as soon as the pulse ends. If power-good is seen low at any point in the pulse, the block takes the cold-boot path instead. On that path it keeps system reset asserted until power-good has been high for a run of consecutive cycles. A status code records which path the last sequence took.

Top module: `hrst_pulse_seq`

## Requirements
- R1: After synchronous reset, all three suspend outputs are high, `sys_rst` is low and `status` is 2'b00 (no sequence since reset).
- R2: A write with `wr_en` high, `wr_addr` equal to 8'hC9, `wr_data[2]` high and `wr_data[1]` high, made while idle, starts a sequence. After the next clock edge, `slp_a_n` and `slp_c_n` are low, `sys_rst` is high and `status` is 2'b01.
- R3: A write that misses bit 1, misses bit 2, or goes to any other address changes no output.
- R4: The pulse ends on the clock edge that samples the fourth `rtc_tick` seen while pulsing. At that edge `slp_a_n` and `slp_c_n` return high. Ticks that arrive while idle are not counted.
- R5: `slp_b_n` stays high at all times.
- R6: If `pwr_good` is high in every cycle of the pulse, `sys_rst` falls on the same edge that ends the pulse, and `status` stays 2'b01.
- R7: If `pwr_good` is sampled low during the pulse, `status` becomes 2'b10 on the next edge, and `sys_rst` stays high after the pulse ends.
- R8: On the cold path, `sys_rst` falls on the 16th consecutive edge that samples `pwr_good` high after the pulse has ended. A low sample restarts the count.
- R9: Trigger writes that arrive during the pulse or the cold wait are ignored. They neither restart the pulse nor change `status`.
- R10: While idle, `status` keeps the code of the last sequence until the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rtc_tick | input | 1 | One-cycle enable per RTC period |
| pwr_good | input | 1 | Power-good from the supply |
| slp_a_n | output | 1 | Suspend plane A, active low |
| slp_b_n | output | 1 | Suspend plane B, active low |
| slp_c_n | output | 1 | Suspend plane C, active low |
| sys_rst | output | 1 | System reset, active high |
| status | output | 2 | 00 none, 01 warm, 10 cold |

## Verification
The bench builds the block with its defaults: a pulse of four ticks and a stability run of sixteen cycles. Both values are small enough that the bench can count each window edge by edge. It can therefore check the cycle just before each release as well as the release cycle itself. The same short windows let the bench exercise the corner cases in one run. These are a power-good drop sampled only on the final tick, a restart of the stability count partway through, and trigger writes landing inside both the pulse and the cold wait.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_COLD  = 2'd2
  } seq_state_t;

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_WARM = 2'b01;
  localparam logic [1:0] CODE_COLD = 2'b10;
endpackage

// File: rtl/hrst_wr_decode.sv
module hrst_wr_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MATCH_ADDR = 8'hC9,
  parameter int GO_BIT = 2,
  parameter int ARM_BIT = 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit
);
  localparam logic [DATA_W-1:0] NEED_MASK =
    (DATA_W'(1) << GO_BIT) | (DATA_W'(1) << ARM_BIT);

  always_comb begin
    hit = wr_en && (wr_addr == MATCH_ADDR) && ((wr_data & NEED_MASK) == NEED_MASK);
  end
endmodule

// File: rtl/hrst_run_cnt.sv
module hrst_run_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    last = inc && !clr && (cnt == TOP);
  end
endmodule

// File: rtl/hrst_pulse_seq.sv
module hrst_pulse_seq
  import hrst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC9,
  parameter int GO_BIT = 2,
  parameter int ARM_BIT = 1,
  parameter int PULSE_TICKS = 4,
  parameter int STABLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rtc_tick,
  input  logic              pwr_good,
  output logic              slp_a_n,
  output logic              slp_b_n,
  output logic              slp_c_n,
  output logic              sys_rst,
  output logic [1:0]        status
);
  seq_state_t st, nxt;
  logic hit, tick_last, stab_last, drop_q;
  logic in_pulse, in_cold;

  assign in_pulse = (st == ST_PULSE);
  assign in_cold  = (st == ST_COLD);

  hrst_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_ADDR(CTRL_ADDR),
    .GO_BIT(GO_BIT), .ARM_BIT(ARM_BIT)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit)
  );

  hrst_run_cnt #(.LIMIT(PULSE_TICKS)) u_tick_cnt (
    .clk(clk), .rst(rst), .clr(!in_pulse),
    .inc(in_pulse && rtc_tick), .last(tick_last)
  );

  hrst_run_cnt #(.LIMIT(STABLE_CYC)) u_stab_cnt (
    .clk(clk), .rst(rst), .clr(!in_cold || !pwr_good),
    .inc(in_cold && pwr_good), .last(stab_last)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (hit) nxt = ST_PULSE;
      ST_PULSE: if (tick_last) nxt = (drop_q || !pwr_good) ? ST_COLD : ST_IDLE;
      ST_COLD:  if (stab_last) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      drop_q  <= 1'b0;
      status  <= CODE_NONE;
      slp_a_n <= 1'b1;
      slp_b_n <= 1'b1;
      slp_c_n <= 1'b1;
      sys_rst <= 1'b0;
    end else begin
      st      <= nxt;
      slp_a_n <= (nxt != ST_PULSE);
      slp_c_n <= (nxt != ST_PULSE);
      slp_b_n <= 1'b1;
      sys_rst <= (nxt != ST_IDLE);
      if (st == ST_IDLE && hit) begin
        drop_q <= 1'b0;
        status <= CODE_WARM;
      end else if (in_pulse && !pwr_good) begin
        drop_q <= 1'b1;
        status <= CODE_COLD;
      end
    end
  end
endmodule

// File: rtl/hrst_pulse_seq_chk.sv
module hrst_pulse_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hC9,
  parameter int GO_BIT = 2,
  parameter int ARM_BIT = 1,
  parameter int STABLE_CYC = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rtc_tick,
  input logic              pwr_good,
  input logic              slp_a_n,
  input logic              slp_c_n,
  input logic              sys_rst,
  input logic [1:0]        status
);
  localparam int RW = $clog2(STABLE_CYC + 1) + 1;
  localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};

  logic trig;
  logic [RW-1:0] hi_run;
  assign trig = wr_en && (wr_addr == CTRL_ADDR) && wr_data[GO_BIT] && wr_data[ARM_BIT];

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) hi_run <= '0;
    else if (hi_run != RUN_MAX) hi_run <= hi_run + 1'b1;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (trig && !sys_rst) |=> (!slp_a_n && !slp_c_n && sys_rst));

  assert_end_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(slp_a_n) |-> $past(rtc_tick));

  assert_warm_release_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(slp_a_n) && status == 2'b01) |-> !sys_rst);

  assert_cold_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(slp_a_n) && status == 2'b10) |-> sys_rst);

  assert_cold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(sys_rst) && status == 2'b10) |-> (hi_run >= RW'(STABLE_CYC)));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst && !trig) |=> $stable(status));
endmodule

bind hrst_pulse_seq hrst_pulse_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .GO_BIT(GO_BIT), .ARM_BIT(ARM_BIT), .STABLE_CYC(STABLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rtc_tick(rtc_tick), .pwr_good(pwr_good), .slp_a_n(slp_a_n),
  .slp_c_n(slp_c_n), .sys_rst(sys_rst), .status(status)
);

// File: tb/hrst_pulse_seq_test.sv
`timescale 1ns/1ps
module hrst_pulse_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rtc_tick = 1'b0;
  logic pwr_good = 1'b1;
  logic slp_a_n, slp_b_n, slp_c_n, sys_rst;
  logic [1:0] status;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hrst_pulse_seq #(.PULSE_TICKS(4), .STABLE_CYC(16)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rtc_tick(rtc_tick), .pwr_good(pwr_good), .slp_a_n(slp_a_n),
    .slp_b_n(slp_b_n), .slp_c_n(slp_c_n), .sys_rst(sys_rst), .status(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic tick(input int gap);
    rtc_tick = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0;
    wait_cyc(gap);
  endtask

  task automatic t_reset();
    check(slp_a_n == 1'b1, "R1 slp_a_n", int'(slp_a_n), 1);
    check(slp_b_n == 1'b1, "R1 slp_b_n", int'(slp_b_n), 1);
    check(slp_c_n == 1'b1, "R1 slp_c_n", int'(slp_c_n), 1);
    check(sys_rst == 1'b0, "R1 sys_rst", int'(sys_rst), 0);
    check(status == 2'b00, "R1 status", int'(status), 0);
  endtask

  task automatic t_ignored_writes();
    bus_write(8'hC9, 8'h04);
    check(slp_a_n && !sys_rst && status == 2'b00, "R3 missing bit1", int'(sys_rst), 0);
    bus_write(8'hC9, 8'h02);
    check(slp_a_n && !sys_rst && status == 2'b00, "R3 missing bit2", int'(sys_rst), 0);
    bus_write(8'hC8, 8'h06);
    check(slp_c_n && !sys_rst && status == 2'b00, "R3 wrong address", int'(sys_rst), 0);
  endtask

  task automatic t_warm();
    tick(1); tick(1);
    bus_write(8'hC9, 8'h06);
    check(!slp_a_n && !slp_c_n, "R2 planes low", int'({slp_a_n, slp_c_n}), 0);
    check(sys_rst == 1'b1 && status == 2'b01, "R2 reset and status", int'(status), 1);
    check(slp_b_n == 1'b1, "R5 slp_b_n in pulse", int'(slp_b_n), 1);
    tick(2); tick(0); tick(3);
    check(!slp_a_n && sys_rst, "R4 low after three ticks", int'(slp_a_n), 0);
    tick(0);
    check(slp_a_n && slp_c_n, "R4 released on fourth tick", int'({slp_a_n, slp_c_n}), 3);
    check(!sys_rst && status == 2'b01, "R6 warm release", int'(sys_rst), 0);
    wait_cyc(5);
    check(status == 2'b01, "R10 status holds warm", int'(status), 1);
  endtask

  task automatic t_retrigger();
    bus_write(8'hC9, 8'hFF);
    tick(1); tick(1);
    bus_write(8'hC9, 8'h06);
    check(!slp_a_n && status == 2'b01, "R9 retrigger in pulse", int'(slp_a_n), 0);
    tick(1);
    tick(0);
    check(slp_a_n && !sys_rst, "R9 pulse not restarted", int'(slp_a_n), 1);
  endtask

  task automatic t_cold();
    bus_write(8'hC9, 8'h06);
    tick(1);
    pwr_good = 1'b0;
    @(negedge clk);
    check(status == 2'b10, "R7 status cold", int'(status), 2);
    pwr_good = 1'b1;
    tick(1); tick(1); tick(0);
    check(slp_a_n && sys_rst, "R7 reset held after pulse", int'(sys_rst), 1);
    check(slp_b_n == 1'b1, "R5 slp_b_n in cold wait", int'(slp_b_n), 1);
    bus_write(8'hC9, 8'h06);
    check(slp_a_n && status == 2'b10, "R9 retrigger in cold wait", int'(slp_a_n), 1);
    wait_cyc(14);
    check(sys_rst == 1'b1, "R8 held at 15 stable", int'(sys_rst), 1);
    wait_cyc(1);
    check(sys_rst == 1'b0, "R8 released at 16 stable", int'(sys_rst), 0);
    check(status == 2'b10, "R10 status holds cold", int'(status), 2);
  endtask

  task automatic t_cold_restart();
    bus_write(8'hC9, 8'h06);
    check(status == 2'b01, "R2 status warm on new trigger", int'(status), 1);
    tick(1); tick(1); tick(1);
    pwr_good = 1'b0;
    tick(0);
    check(slp_a_n && sys_rst && status == 2'b10, "R7 drop on last tick", int'(status), 2);
    wait_cyc(5);
    pwr_good = 1'b1;
    wait_cyc(10);
    check(sys_rst == 1'b1, "R8 held mid run", int'(sys_rst), 1);
    pwr_good = 1'b0;
    wait_cyc(1);
    pwr_good = 1'b1;
    wait_cyc(15);
    check(sys_rst == 1'b1, "R8 restart held at 15", int'(sys_rst), 1);
    wait_cyc(1);
    check(sys_rst == 1'b0, "R8 restart released at 16", int'(sys_rst), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_ignored_writes();
    t_warm();
    t_retrigger();
    t_cold();
    t_cold_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule